// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block sits inside an SDRAM controller and owns every refresh decision. A free-running interval counter marks each point where one auto-refresh falls due. Each one adds to a small backlog, and the block raises a request to the command arbiter while the backlog is non-zero. On a grant it emits a one-cycle refresh strobe. It then holds a busy flag for the full row cycle time, so the arbiter issues nothing else in that window. Refreshes may be postponed while the arbiter is occupied. When the backlog reaches a configured ceiling, an urgent flag asks the arbiter to serve refresh first.

The block also runs low-power retention. A level request, accepted only while everything is quiet and all banks are idle, drops the clock-enable line. The line stays low for at least the minimum active time and for as long as the request is held. When the request falls, clock enable rises and the block keeps the bus on NOPs for the longer of two clocks and the row cycle time. Because the device's internal row position is then unknown, the block fires a back-to-back burst of auto-refreshes covering every row. Each is spaced by the row cycle time. Only after the burst does normal traffic resume.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: After reset, cke is 1 and ref_req, ref_urgent, ref_cmd and busy are 0, while idle_ok is 1.
- R2: In normal operation a refresh falls due every REFI_CYC clocks, counted from reset release. ref_req is 1 whenever at least one due refresh is outstanding.
- R3: When ref_req and arb_grant are both 1 at a clock edge, ref_cmd is 1 for exactly the following cycle. busy is 1 for exactly TRC_CYC cycles starting with that cycle, and ref_req is 0 during those cycles.
- R4: The outstanding count saturates at MAX_POSTPONE. ref_urgent is 1 exactly when ref_req is 1 and the count equals MAX_POSTPONE. Draining a saturated backlog yields exactly MAX_POSTPONE strobes.
- R5: Without arb_grant no refresh strobe is issued in normal operation, however long refreshes are outstanding.
- R6: A self-refresh request (sr_req = 1) is accepted only if busy is 0, nothing is outstanding and banks_idle is 1. cke then falls in the cycle after acceptance. Otherwise cke stays 1.
- R7: Once low, cke stays low for at least TRAS_CYC cycles. It also stays low for as long as sr_req remains 1, and rises at the first edge that sees sr_req at 0 after that minimum.
- R8: After cke rises, busy stays 1 and no strobe is issued for exactly max(2, TRC_CYC) cycles.
- R9: Next comes a burst of exactly BURST_ROWS strobes, TRC_CYC cycles apart and independent of arb_grant. busy falls TRC_CYC cycles after the last strobe, and the next refresh falls due REFI_CYC cycles after that.
- R10: idle_ok is 1 exactly when busy is 0 and no refresh is outstanding.
- R11: While cke is 0, busy is 1, no strobe is issued, and arb_grant has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Level request to enter (1) or leave (0) self-refresh |
| banks_idle | input | 1 | Arbiter reports all banks precharged |
| arb_grant | input | 1 | Arbiter grants the pending refresh |
| ref_req | output | 1 | A refresh is outstanding and wants the bus |
| ref_urgent | output | 1 | Backlog at its ceiling; serve refresh first |
| ref_cmd | output | 1 | One-cycle auto-refresh command strobe |
| cke | output | 1 | Clock-enable level to the SDRAM |
| busy | output | 1 | Other commands must be held off |
| idle_ok | output | 1 | No refresh activity outstanding or running |

## Verification
A wrong timer load or decrement appears directly as a mis-sized busy window, or a mis-spaced strobe, within one row cycle of the event. A drifting interval counter or backlog shows up as ref_req rising on the wrong cycle, or as a strobe count that differs from the expected number after a saturated drain. A bad self-refresh state shows up as cke rising too early or too late, a strobe while cke is low, or a burst count or exit gap that is off by one cycle. All of these are visible within a few tens of cycles.

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr #(
  parameter int REFI_CYC     = 3120,
  parameter int TRC_CYC      = 13,
  parameter int TRAS_CYC     = 9,
  parameter int MAX_POSTPONE = 8,
  parameter int BURST_ROWS   = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_req,
  input  logic banks_idle,
  input  logic arb_grant,
  output logic ref_req,
  output logic ref_urgent,
  output logic ref_cmd,
  output logic cke,
  output logic busy,
  output logic idle_ok
);

  localparam int EXIT_CYC = (TRC_CYC > 2) ? TRC_CYC : 2;
  localparam int TMAX     = (TRAS_CYC > EXIT_CYC) ? TRAS_CYC : EXIT_CYC;
  localparam int CW       = $clog2(TMAX + 1);
  localparam int RW       = $clog2(REFI_CYC + 1);
  localparam int PW       = $clog2(MAX_POSTPONE + 1);
  localparam int BW       = $clog2(BURST_ROWS + 1);

  typedef enum logic [1:0] {S_RUN, S_RC, S_SR, S_XNOP} st_t;

  st_t           st;
  logic [CW-1:0] tmr;
  logic [RW-1:0] ivl;
  logic [PW-1:0] pend;
  logic [BW-1:0] left;
  logic          burst;
  logic          due;
  logic          take;
  logic          sr_go;
  logic          quiet;

  assign quiet      = (st == S_SR) || (st == S_XNOP) || burst;
  assign due        = !quiet && (ivl == RW'(REFI_CYC - 1));
  assign ref_req    = (st == S_RUN) && (pend != '0);
  assign ref_urgent = ref_req && (pend == PW'(MAX_POSTPONE));
  assign take       = ref_req && arb_grant;
  assign sr_go      = (st == S_RUN) && sr_req && banks_idle && (pend == '0);
  assign cke        = (st != S_SR);
  assign busy       = (st != S_RUN);
  assign idle_ok    = !busy && (pend == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ivl <= '0;
    else if (quiet || due)
      ivl <= '0;
    else
      ivl <= ivl + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend <= '0;
    else if (quiet)
      pend <= '0;
    else if (due && !take && pend != PW'(MAX_POSTPONE))
      pend <= pend + PW'(1);
    else if (take && !due)
      pend <= pend - PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_RUN;
      tmr     <= '0;
      left    <= '0;
      burst   <= 1'b0;
      ref_cmd <= 1'b0;
    end else begin
      ref_cmd <= 1'b0;
      case (st)
        S_RUN: begin
          if (take) begin
            st      <= S_RC;
            tmr     <= CW'(TRC_CYC - 1);
            ref_cmd <= 1'b1;
          end else if (sr_go) begin
            st  <= S_SR;
            tmr <= CW'(TRAS_CYC - 1);
          end
        end
        S_RC: begin
          if (tmr != '0)
            tmr <= tmr - CW'(1);
          else if (burst && left != '0) begin
            tmr     <= CW'(TRC_CYC - 1);
            left    <= left - BW'(1);
            ref_cmd <= 1'b1;
          end else begin
            st    <= S_RUN;
            burst <= 1'b0;
          end
        end
        S_SR: begin
          if (tmr != '0)
            tmr <= tmr - CW'(1);
          else if (!sr_req) begin
            st  <= S_XNOP;
            tmr <= CW'(EXIT_CYC - 1);
          end
        end
        default: begin
          if (tmr != '0)
            tmr <= tmr - CW'(1);
          else begin
            st      <= S_RC;
            tmr     <= CW'(TRC_CYC - 1);
            left    <= BW'(BURST_ROWS - 1);
            burst   <= 1'b1;
            ref_cmd <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_refresh_mgr_chk.sv
module sdram_refresh_mgr_chk #(
  parameter int TRC_CYC  = 13,
  parameter int TRAS_CYC = 9
) (
  input logic clk,
  input logic rst_n,
  input logic sr_req,
  input logic banks_idle,
  input logic arb_grant,
  input logic ref_req,
  input logic ref_urgent,
  input logic ref_cmd,
  input logic cke,
  input logic busy,
  input logic idle_ok
);

  localparam int LW = $clog2(TRAS_CYC + 1);
  localparam int GW = $clog2(TRC_CYC + 1);

  logic [LW-1:0] low_n;
  logic [GW-1:0] gap_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_n <= '0;
      gap_n <= GW'(TRC_CYC);
    end else begin
      if (cke) low_n <= '0;
      else if (low_n != LW'(TRAS_CYC)) low_n <= low_n + LW'(1);
      if (ref_cmd) gap_n <= '0;
      else if (gap_n != GW'(TRC_CYC)) gap_n <= gap_n + GW'(1);
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |=> !ref_cmd);
  a_r3_cmd_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> (busy && !ref_req));
  a_r3_grant_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && arb_grant) |=> ref_cmd);
  a_r4_urgent_req: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req);
  a_r6_entry_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(sr_req && banks_idle && idle_ok));
  a_r7_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_n >= LW'(TRAS_CYC)));
  a_r8_exit_nops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (!ref_cmd && busy) ##1 (!ref_cmd && busy));
  a_r9_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> (gap_n >= GW'(TRC_CYC - 1)));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ok |-> (!busy && !ref_req));
  a_r11_quiet_sr: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (busy && !ref_cmd && !ref_req));

endmodule

bind sdram_refresh_mgr sdram_refresh_mgr_chk #(
  .TRC_CYC (TRC_CYC),
  .TRAS_CYC(TRAS_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sr_req    (sr_req),
  .banks_idle(banks_idle),
  .arb_grant (arb_grant),
  .ref_req   (ref_req),
  .ref_urgent(ref_urgent),
  .ref_cmd   (ref_cmd),
  .cke       (cke),
  .busy      (busy),
  .idle_ok   (idle_ok)
);

// File: tb/sdram_refresh_mgr_tb_top.sv
`timescale 1ns/1ps
module sdram_refresh_mgr_tb_top;

  localparam int REFI  = 40;
  localparam int TRC   = 4;
  localparam int TRAS  = 6;
  localparam int MAXP  = 3;
  localparam int BURST = 5;
  localparam int EXIT  = (TRC > 2) ? TRC : 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_req = 1'b0;
  logic banks_idle = 1'b0;
  logic arb_grant = 1'b0;
  logic ref_req, ref_urgent, ref_cmd, cke, busy, idle_ok;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sdram_refresh_mgr #(
    .REFI_CYC(REFI), .TRC_CYC(TRC), .TRAS_CYC(TRAS),
    .MAX_POSTPONE(MAXP), .BURST_ROWS(BURST)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .banks_idle(banks_idle),
    .arb_grant(arb_grant), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .ref_cmd(ref_cmd), .cke(cke), .busy(busy), .idle_ok(idle_ok)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    sr_req = 0; arb_grant = 0; banks_idle = 0;
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cke", cke, 1);
    chk("R1 ref_req", ref_req, 0);
    chk("R1 ref_urgent", ref_urgent, 0);
    chk("R1 ref_cmd", ref_cmd, 0);
    chk("R1 busy", busy, 0);
    chk("R1 idle_ok", idle_ok, 1);
  endtask

  task automatic t_interval_and_grant();
    int n = 0;
    int b = 1;
    int pulses = 1;
    do_reset();
    while (!ref_req && n < 1000) begin step(); n++; end
    chk("R2 interval", n, REFI);
    chk("R10 idle_ok with backlog", idle_ok, 0);
    arb_grant = 1;
    step();
    arb_grant = 0;
    chk("R3 strobe", ref_cmd, 1);
    chk("R3 busy", busy, 1);
    chk("R3 req cleared", ref_req, 0);
    while (b < 100) begin
      step();
      if (!busy) break;
      b++;
      if (ref_cmd) pulses++;
    end
    chk("R3 busy length", b, TRC);
    chk("R3 single strobe", pulses, 1);
    chk("R10 idle_ok after", idle_ok, 1);
  endtask

  task automatic t_postpone();
    int strobes = 0;
    int n = 0;
    do_reset();
    repeat (MAXP * REFI - 1) begin step(); if (ref_cmd) strobes++; end
    chk("R4 not yet urgent", ref_urgent, 0);
    step();
    chk("R4 urgent", ref_urgent, 1);
    repeat (REFI) begin step(); if (ref_cmd) strobes++; end
    chk("R4 still urgent", ref_urgent, 1);
    chk("R5 no strobe without grant", strobes, 0);
    arb_grant = 1;
    while ((ref_req || busy) && n < 200) begin
      step(); n++;
      if (ref_cmd) strobes++;
    end
    arb_grant = 0;
    chk("R4 drained count", strobes, MAXP);
  endtask

  task automatic t_sr_reject();
    do_reset();
    sr_req = 1; banks_idle = 0;
    repeat (4) step();
    chk("R6 banks busy reject", cke, 1);
    sr_req = 0;
    repeat (REFI - 4) step();
    chk("R6 backlog present", ref_req, 1);
    sr_req = 1; banks_idle = 1;
    repeat (3) step();
    chk("R6 backlog reject", cke, 1);
    sr_req = 0;
  endtask

  task automatic t_sr_cycle();
    int low = 1;
    int refs = 0;
    int c = 0;
    int g = 0;
    int pulses = 1;
    int notbusy = 0;
    int n = 0;
    do_reset();
    banks_idle = 1; sr_req = 1;
    step();
    chk("R6 cke falls", cke, 0);
    sr_req = 0; arb_grant = 1;
    while (!cke && low < 100) begin
      step();
      if (ref_cmd) refs++;
      if (!cke) low++;
    end
    chk("R7 minimum low", low, TRAS);
    chk("R11 no strobe while low", refs, 0);
    while (!ref_cmd && c < 100) begin
      step(); c++;
      if (!busy) notbusy++;
    end
    chk("R8 exit gap", c, EXIT);
    chk("R8 busy through exit", notbusy, 0);
    while (g < 100) begin
      step(); g++;
      if (!busy) break;
      if (ref_cmd) begin
        chk("R9 burst spacing", g, TRC);
        pulses++;
        g = 0;
      end
    end
    arb_grant = 0;
    chk("R9 burst count", pulses, BURST);
    chk("R9 tail", g, TRC);
    chk("R9 backlog clear", ref_req, 0);
    while (!ref_req && n < 1000) begin step(); n++; end
    chk("R9 interval restart", n, REFI);
  endtask

  task automatic t_sr_hold();
    int low = 1;
    do_reset();
    banks_idle = 1; sr_req = 1;
    step();
    repeat (15) begin step(); if (!cke) low++; end
    sr_req = 0;
    step();
    chk("R7 held low", low, 16);
    chk("R7 rise after release", cke, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_interval_and_grant();
    t_postpone();
    t_sr_reject();
    t_sr_cycle();
    t_sr_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule